// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the memory-mapped face of a platform interrupt controller. It takes single 32-bit word reads and writes from a simple valid/ready request bus and returns a one-cycle response. The address is decoded into four windows: one priority word per source, a read-only pending bitmap, per-context enable bitmaps, and per-context threshold and claim/complete registers. The window bases and the two context strides are parameters.

The block holds the software-visible configuration (source priorities, enable bitmaps, context thresholds) and exposes it as flat vectors to the arbiter next to it. The arbiter supplies the live pending bits and, for every context, the ID of the source it would hand out now. A read of a context's claim register returns that ID and raises a single claim strobe. A write to the same register raises a completion strobe carrying the written ID.

Top module: `irq_reg_frontend`

## Requirements
- R1: An access whose address has bit 1 or bit 0 set is rejected: a read returns zero, a write changes nothing, and neither a claim nor a completion strobe is raised.
- R2: An aligned access outside every window, or at an offset inside a context block other than 0 and 4, reads as zero and has no effect when written.
- R3: Priority word k of the priority window (byte offset 4*k) belongs to source k+1. A write keeps only the low PRIO_W bits, and a read returns them zero-extended.
- R4: Pending word w, bit b reports the pending input of source ID 32*w+b. Source s drives srcPending[s-1], and bit 0 of word 0 (ID 0) always reads as zero.
- R5: Writes to the pending window are discarded and change no output of the block.
- R6: In the enable window, the context is the offset divided by EN_STRIDE and the word is the remainder divided by four. Bit b of word w enables source 32*w+b. Bits for IDs outside 1..NUM_SRC are never stored and read as zero.
- R7: An enable word whose index is at or beyond ceil((NUM_SRC+1)/32) reads as zero and ignores writes.
- R8: Offset 0 of a context block is its threshold. A write of a value greater than 2^PRIO_W-1 is ignored, and any other value is stored.
- R9: Each accepted read of a context's claim register (offset 4) returns that context's ctxClaimId. In the response cycle it raises claimStb exactly once, with claimCtx and claimId equal to the context and the returned ID. A request held through a stall raises no second strobe.
- R10: A write to offset 4 of a context block raises doneStb for one cycle in the response cycle, with doneCtx and doneId, if the written value is 1..NUM_SRC. Any other value raises nothing.
- R11: A request is accepted when reqValid and reqReady are both high. rspValid pulses high for exactly the next cycle, and reqReady is low during that cycle. rspData carries the read value, and is zero for writes and outside responses. Register bit k is data bit k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle response pulse |
| rspData | output | 32 | Read data, zero for writes |
| srcPending | input | NUM_SRC | Pending flags, source s at bit s-1 |
| ctxClaimId | input | NUM_CTX*ID_W | Arbiter's current winner per context |
| srcPrio | output | NUM_SRC*PRIO_W | Stored priorities, source s at slice s-1 |
| ctxEnable | output | NUM_CTX*EN_BITS | Stored enable bitmaps, one slice per context |
| ctxThreshold | output | NUM_CTX*PRIO_W | Stored thresholds |
| claimStb | output | 1 | Claim performed |
| claimCtx | output | CTX_W | Context of the claim |
| claimId | output | ID_W | ID handed out by the claim |
| doneStb | output | 1 | Completion received |
| doneCtx | output | CTX_W | Context of the completion |
| doneId | output | ID_W | Completed source ID |

## Verification
A corrupted priority, enable or threshold register shows up on the configuration vectors one cycle after the write that caused it, well before any read-back could expose it. A decode or response-timing fault shows in rspData or in the strobes on the cycle right after acceptance. The reference model predicts every output on every cycle, so the first divergence is reported at the cycle where it occurs. The weakest point is a second claim strobe: it can only appear when the bench holds a request through a stall, and that case is driven on purpose.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int WORD_BITS = 32;
  localparam int CTX_IW = 8;
  localparam int IDX_W = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PRIO, SEL_PEND, SEL_EN, SEL_THR, SEL_CLAIM
  } regSel_e;

  // Decoded command from control to datapath
  typedef struct packed {
    logic                 acc;
    logic                 wr;
    regSel_e              sel;
    logic [CTX_IW-1:0]    ctx;
    logic [IDX_W-1:0]     idx;
    logic [WORD_BITS-1:0] wdata;
  } feCmd_t;

  // Words covering IDs 0..nSrc
  function automatic int wordsFor(int nSrc);
    return (nSrc + WORD_BITS) / WORD_BITS;
  endfunction
endpackage

// File: rtl/irqfe_ctrl.sv
module irqfe_ctrl import irqfe_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NUM_SRC = 40,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_BASE = 'h0004,
  parameter int unsigned PEND_BASE = 'h1000,
  parameter int unsigned EN_BASE = 'h2000,
  parameter int unsigned EN_STRIDE = 'h80,
  parameter int unsigned CTX_BASE = 'h4000,
  parameter int unsigned CTX_STRIDE = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output feCmd_t            cmd
);
  localparam int unsigned EN_WORDS = wordsFor(NUM_SRC);
  localparam int unsigned EN_SH = $clog2(EN_STRIDE);
  localparam int unsigned CTX_SH = $clog2(CTX_STRIDE);
  localparam logic [31:0] PRIO_END = 32'(PRIO_BASE + NUM_SRC * 4);
  localparam logic [31:0] PEND_END = 32'(PEND_BASE + EN_WORDS * 4);
  localparam logic [31:0] EN_END = 32'(EN_BASE + NUM_CTX * EN_STRIDE);
  localparam logic [31:0] CTX_END = 32'(CTX_BASE + NUM_CTX * CTX_STRIDE);

  logic        rspValidQ;
  logic [31:0] addr;
  logic [31:0] off;
  logic [31:0] inner;

  assign reqReady = !rspValidQ;
  assign rspValid = rspValidQ;
  assign addr = 32'(reqAddr);

  always_comb begin
    cmd = '0;
    cmd.acc = reqValid && reqReady;
    cmd.wr = reqWrite;
    cmd.wdata = reqWdata;
    cmd.sel = SEL_NONE;
    off = '0;
    inner = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= PRIO_BASE && addr < PRIO_END) begin
        off = addr - PRIO_BASE;
        cmd.sel = SEL_PRIO;
        cmd.idx = IDX_W'(off >> 2);
      end else if (addr >= PEND_BASE && addr < PEND_END) begin
        off = addr - PEND_BASE;
        cmd.sel = SEL_PEND;
        cmd.idx = IDX_W'(off >> 2);
      end else if (addr >= EN_BASE && addr < EN_END) begin
        off = addr - EN_BASE;
        inner = off & (EN_STRIDE - 1);
        cmd.ctx = CTX_IW'(off >> EN_SH);
        cmd.idx = IDX_W'(inner >> 2);
        if ((inner >> 2) < EN_WORDS) cmd.sel = SEL_EN;
      end else if (addr >= CTX_BASE && addr < CTX_END) begin
        off = addr - CTX_BASE;
        inner = off & (CTX_STRIDE - 1);
        cmd.ctx = CTX_IW'(off >> CTX_SH);
        if (inner == 32'd0) cmd.sel = SEL_THR;
        else if (inner == 32'd4) cmd.sel = SEL_CLAIM;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValidQ <= 1'b0;
    else       rspValidQ <= cmd.acc;
  end
endmodule

// File: rtl/irqfe_dp.sv
module irqfe_dp import irqfe_pkg::*; #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W = 3,
  localparam int EN_WORDS = wordsFor(NUM_SRC),
  localparam int EN_BITS = EN_WORDS * WORD_BITS,
  localparam int ID_W = $clog2(NUM_SRC + 1),
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  feCmd_t                      cmd,
  input  logic [NUM_SRC-1:0]          srcPending,
  input  logic [NUM_CTX*ID_W-1:0]     ctxClaimId,
  output logic [31:0]                 rspData,
  output logic [NUM_SRC*PRIO_W-1:0]   srcPrio,
  output logic [NUM_CTX*EN_BITS-1:0]  ctxEnable,
  output logic [NUM_CTX*PRIO_W-1:0]   ctxThreshold,
  output logic                        claimStb,
  output logic [CTX_W-1:0]            claimCtx,
  output logic [ID_W-1:0]             claimId,
  output logic                        doneStb,
  output logic [CTX_W-1:0]            doneCtx,
  output logic [ID_W-1:0]             doneId
);
  localparam int SRC_IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int WIDX_W = (EN_WORDS > 1) ? $clog2(EN_WORDS) : 1;
  localparam logic [31:0] MAX_PRIO = 32'((1 << PRIO_W) - 1);
  localparam logic [31:0] LAST_ID = 32'(NUM_SRC);

  logic [PRIO_W-1:0]  prioQ [NUM_SRC];
  logic [EN_BITS-1:0] enQ   [NUM_CTX];
  logic [PRIO_W-1:0]  thrQ  [NUM_CTX];

  logic [EN_BITS-1:0] validMask;
  logic [EN_BITS-1:0] pendVec;
  logic [SRC_IW-1:0]  srcIdx;
  logic [WIDX_W-1:0]  wordIdx;
  logic [CTX_W-1:0]   ctxIdx;
  logic [ID_W-1:0]    claimPick;
  logic [31:0]        rdNext;
  logic               rdAcc;
  logic               wrAcc;
  logic               unusedBits;

  assign srcIdx = cmd.idx[SRC_IW-1:0];
  assign wordIdx = cmd.idx[WIDX_W-1:0];
  assign ctxIdx = cmd.ctx[CTX_W-1:0];
  assign unusedBits = ^{cmd.idx, cmd.ctx};
  assign rdAcc = cmd.acc && !cmd.wr;
  assign wrAcc = cmd.acc && cmd.wr;
  assign pendVec = EN_BITS'({srcPending, 1'b0});
  assign claimPick = ctxClaimId[ctxIdx*ID_W +: ID_W];

  for (genvar b = 0; b < EN_BITS; b++) begin : g_mask
    assign validMask[b] = (b >= 1) && (b <= NUM_SRC);
  end
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_prioOut
    assign srcPrio[s*PRIO_W +: PRIO_W] = prioQ[s];
  end
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctxOut
    assign ctxEnable[c*EN_BITS +: EN_BITS] = enQ[c];
    assign ctxThreshold[c*PRIO_W +: PRIO_W] = thrQ[c];
  end

  always_comb begin
    unique case (cmd.sel)
      SEL_PRIO:  rdNext = 32'(prioQ[srcIdx]);
      SEL_PEND:  rdNext = pendVec[wordIdx*WORD_BITS +: WORD_BITS];
      SEL_EN:    rdNext = enQ[ctxIdx][wordIdx*WORD_BITS +: WORD_BITS];
      SEL_THR:   rdNext = 32'(thrQ[ctxIdx]);
      SEL_CLAIM: rdNext = 32'(claimPick);
      default:   rdNext = '0;
    endcase
  end

  // Configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SRC; s++) prioQ[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        enQ[c] <= '0;
        thrQ[c] <= '0;
      end
    end else if (wrAcc) begin
      case (cmd.sel)
        SEL_PRIO: prioQ[srcIdx] <= cmd.wdata[PRIO_W-1:0];
        SEL_EN: enQ[ctxIdx][wordIdx*WORD_BITS +: WORD_BITS] <=
                  cmd.wdata & validMask[wordIdx*WORD_BITS +: WORD_BITS];
        SEL_THR: if (cmd.wdata <= MAX_PRIO) thrQ[ctxIdx] <= cmd.wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  // Response data and strobes, one cycle after acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      claimStb <= 1'b0;
      claimCtx <= '0;
      claimId <= '0;
      doneStb <= 1'b0;
      doneCtx <= '0;
      doneId <= '0;
    end else begin
      rspData <= rdAcc ? rdNext : '0;
      claimStb <= 1'b0;
      claimCtx <= '0;
      claimId <= '0;
      doneStb <= 1'b0;
      doneCtx <= '0;
      doneId <= '0;
      if (rdAcc && cmd.sel == SEL_CLAIM) begin
        claimStb <= 1'b1;
        claimCtx <= ctxIdx;
        claimId <= claimPick;
      end
      if (wrAcc && cmd.sel == SEL_CLAIM && cmd.wdata != '0 && cmd.wdata <= LAST_ID) begin
        doneStb <= 1'b1;
        doneCtx <= ctxIdx;
        doneId <= cmd.wdata[ID_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_reg_frontend.sv
module irq_reg_frontend import irqfe_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int NUM_SRC = 40,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W = 3,
  parameter int PRIO_BASE = 'h0004,
  parameter int PEND_BASE = 'h1000,
  parameter int EN_BASE = 'h2000,
  parameter int EN_STRIDE = 'h80,
  parameter int CTX_BASE = 'h4000,
  parameter int CTX_STRIDE = 'h1000,
  localparam int EN_BITS = wordsFor(NUM_SRC) * WORD_BITS,
  localparam int ID_W = $clog2(NUM_SRC + 1),
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [31:0]                 reqWdata,
  output logic                        rspValid,
  output logic [31:0]                 rspData,
  input  logic [NUM_SRC-1:0]          srcPending,
  input  logic [NUM_CTX*ID_W-1:0]     ctxClaimId,
  output logic [NUM_SRC*PRIO_W-1:0]   srcPrio,
  output logic [NUM_CTX*EN_BITS-1:0]  ctxEnable,
  output logic [NUM_CTX*PRIO_W-1:0]   ctxThreshold,
  output logic                        claimStb,
  output logic [CTX_W-1:0]            claimCtx,
  output logic [ID_W-1:0]             claimId,
  output logic                        doneStb,
  output logic [CTX_W-1:0]            doneCtx,
  output logic [ID_W-1:0]             doneId
);
  feCmd_t cmd;

  irqfe_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX),
    .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE),
    .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .cmd(cmd)
  );

  irqfe_dp #(
    .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .srcPending(srcPending),
    .ctxClaimId(ctxClaimId), .rspData(rspData), .srcPrio(srcPrio),
    .ctxEnable(ctxEnable), .ctxThreshold(ctxThreshold),
    .claimStb(claimStb), .claimCtx(claimCtx), .claimId(claimId),
    .doneStb(doneStb), .doneCtx(doneCtx), .doneId(doneId)
  );
endmodule

// File: rtl/irqfe_checker.sv
module irqfe_checker #(
  parameter int NUM_SRC = 40,
  parameter int ID_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            reqWrite,
  input logic [1:0]      addrLow,
  input logic            rspValid,
  input logic [31:0]     rspData,
  input logic            claimStb,
  input logic [ID_W-1:0] claimId,
  input logic            doneStb,
  input logic [ID_W-1:0] doneId
);
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady); // R11
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid); // R11
  AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> (rspData == 32'd0)); // R11
  AST_MISALIGNED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && addrLow != 2'b00) |=> (rspData == 32'd0 && !claimStb && !doneStb)); // R1
  AST_CLAIM_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    claimStb |-> (rspValid && rspData == 32'(claimId) && $past(reqValid && reqReady && !reqWrite))); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(claimStb && doneStb)); // R9
  AST_DONE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (doneId != '0 && 32'(doneId) <= NUM_SRC && $past(reqValid && reqReady && reqWrite))); // R10
endmodule

bind irq_reg_frontend irqfe_checker #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .addrLow(reqAddr[1:0]), .rspValid(rspValid),
  .rspData(rspData), .claimStb(claimStb), .claimId(claimId),
  .doneStb(doneStb), .doneId(doneId)
);

// File: tb/tb_irq_reg_frontend.sv
`timescale 1ns/1ps
module tb_irq_reg_frontend;
  localparam int NS = 40;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int IDW = 6;
  localparam int ENB = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN, reqValid, reqReady, reqWrite, rspValid;
  logic [15:0]       reqAddr;
  logic [31:0]       reqWdata, rspData;
  logic [NS-1:0]     pendIn;
  logic [IDW-1:0]    cid0, cid1;
  logic [NS*PW-1:0]  srcPrio;
  logic [NC*ENB-1:0] ctxEnable;
  logic [NC*PW-1:0]  ctxThreshold;
  logic              claimStb, claimCtx, doneStb, doneCtx;
  logic [IDW-1:0]    claimId, doneId;

  irq_reg_frontend #(.ADDR_W(16), .NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .srcPending(pendIn),
    .ctxClaimId({cid1, cid0}), .srcPrio(srcPrio), .ctxEnable(ctxEnable),
    .ctxThreshold(ctxThreshold), .claimStb(claimStb), .claimCtx(claimCtx),
    .claimId(claimId), .doneStb(doneStb), .doneCtx(doneCtx), .doneId(doneId)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R11";

  // Behavioural reference state
  int          mPrio [NS+1];
  logic [31:0] mEn [NC][2];
  int          mThr [NC];
  logic        eRspValid, eReady, eClaim, eClaimCtx, eDone, eDoneCtx;
  logic [31:0] eRspData;
  logic [IDW-1:0] eClaimId, eDoneId;

  function automatic logic [31:0] enMask(int w);
    return (w == 0) ? 32'hFFFF_FFFE : 32'h0000_01FF;
  endfunction

  function automatic logic [IDW-1:0] cidOf(int c);
    return (c == 0) ? cid0 : cid1;
  endfunction

  function automatic bit isClaimReg(logic [15:0] a);
    int x = int'(a);
    return (x % 4 == 0) && x >= 'h4000 && x < 'h6000 && ((x - 'h4000) % 'h1000) == 4;
  endfunction

  function automatic logic [31:0] modelRead(logic [15:0] a);
    int x = int'(a);
    logic [63:0] pv = {23'b0, pendIn, 1'b0};
    if (x % 4 != 0) return 32'd0;
    if (x >= 4 && x < 4 + NS * 4) return 32'(mPrio[x / 4]);
    if (x >= 'h1000 && x < 'h1008) return pv[(x - 'h1000) * 8 +: 32];
    if (x >= 'h2000 && x < 'h2100) begin
      int c = (x - 'h2000) / 'h80;
      int w = ((x - 'h2000) % 'h80) / 4;
      return (w < 2) ? mEn[c][w] : 32'd0;
    end
    if (x >= 'h4000 && x < 'h6000) begin
      int c = (x - 'h4000) / 'h1000;
      int r = (x - 'h4000) % 'h1000;
      if (r == 0) return 32'(mThr[c]);
      if (r == 4) return 32'(cidOf(c));
    end
    return 32'd0;
  endfunction

  task automatic modelWrite(logic [15:0] a, logic [31:0] d);
    int x = int'(a);
    if (x % 4 != 0) return;
    if (x >= 4 && x < 4 + NS * 4) mPrio[x / 4] = int'(d & 32'd7);
    else if (x >= 'h2000 && x < 'h2100) begin
      int c = (x - 'h2000) / 'h80;
      int w = ((x - 'h2000) % 'h80) / 4;
      if (w < 2) mEn[c][w] = d & enMask(w);
    end else if (x >= 'h4000 && x < 'h6000) begin
      int c = (x - 'h4000) / 'h1000;
      if ((x - 'h4000) % 'h1000 == 0 && d <= 32'd7) mThr[c] = int'(d);
    end
  endtask

  task automatic cmp(string what, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic [NS*PW-1:0]  xPrio;
    logic [NC*ENB-1:0] xEn;
    logic [NC*PW-1:0]  xThr;
    for (int s = 1; s <= NS; s++) xPrio[(s-1)*PW +: PW] = PW'(mPrio[s]);
    for (int c = 0; c < NC; c++) begin
      xEn[c*ENB +: ENB] = {mEn[c][1], mEn[c][0]};
      xThr[c*PW +: PW] = PW'(mThr[c]);
    end
    cmp("rspValid", 128'(rspValid), 128'(eRspValid));
    cmp("reqReady", 128'(reqReady), 128'(eReady));
    cmp("rspData", 128'(rspData), 128'(eRspData));
    cmp("claim", 128'({claimStb, claimCtx, claimId}), 128'({eClaim, eClaimCtx, eClaimId}));
    cmp("done", 128'({doneStb, doneCtx, doneId}), 128'({eDone, eDoneCtx, eDoneId}));
    cmp("srcPrio", 128'(srcPrio), 128'(xPrio));
    cmp("ctxEnable", 128'(ctxEnable), 128'(xEn));
    cmp("ctxThreshold", 128'(ctxThreshold), 128'(xThr));
  endtask

  task automatic idleExp();
    eRspValid = 0; eReady = 1; eRspData = 0;
    eClaim = 0; eClaimCtx = 0; eClaimId = 0;
    eDone = 0; eDoneCtx = 0; eDoneId = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    checkAll();
  endtask

  task automatic access(string req, bit wr, logic [15:0] a, logic [31:0] d, bit hold);
    int c = (int'(a) - 'h4000) / 'h1000;
    curReq = req;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    idleExp();
    eRspValid = 1; eReady = 0;
    eRspData = wr ? 32'd0 : modelRead(a);
    if (isClaimReg(a)) begin
      if (!wr) begin
        eClaim = 1; eClaimCtx = c[0]; eClaimId = cidOf(c);
      end else if (d >= 1 && d <= NS) begin
        eDone = 1; eDoneCtx = c[0]; eDoneId = d[IDW-1:0];
      end
    end
    if (wr) modelWrite(a, d);
    tick();
    if (!hold) reqValid = 0;
    idleExp();
    tick();
    reqValid = 0;
  endtask

  task automatic rd(string req, logic [15:0] a);
    access(req, 1'b0, a, 32'd0, 1'b0);
  endtask

  task automatic wrr(string req, logic [15:0] a, logic [31:0] d);
    access(req, 1'b1, a, d, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      mismatched++;
      $display("FAIL R11 watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = 0; reqWdata = 0;
    pendIn = '0; cid0 = 0; cid1 = 0;
    for (int s = 0; s <= NS; s++) mPrio[s] = 0;
    for (int c = 0; c < NC; c++) begin
      mThr[c] = 0; mEn[c][0] = 0; mEn[c][1] = 0;
    end
    idleExp();
    curReq = "R11";
    repeat (3) tick();
    rstN = 1;
    tick();

    // R3: priority words, source = offset/4
    wrr("R3", 16'h0004, 32'hFFFF_FFFF);
    wrr("R3", 16'h00A0, 32'd5);
    wrr("R3", 16'h0050, 32'd2);
    rd("R3", 16'h0004);
    rd("R3", 16'h00A0);
    rd("R3", 16'h0050);
    // R2: unmapped
    rd("R2", 16'h00A4);
    wrr("R2", 16'h3000, 32'hFFFF_FFFF);
    rd("R2", 16'h3000);
    rd("R2", 16'h4008);
    wrr("R2", 16'h5010, 32'd3);
    rd("R2", 16'h0000);
    // R1: misaligned
    wrr("R1", 16'h0006, 32'd3);
    rd("R1", 16'h0005);
    cid0 = 6'd9;
    rd("R1", 16'h4005);
    wrr("R1", 16'h4006, 32'd3);
    // R4: pending readback
    pendIn = 40'h80_0000_0001 | 40'h00_8000_0000;
    rd("R4", 16'h1000);
    rd("R4", 16'h1004);
    pendIn = 40'h5A_A5A5_5A5A;
    rd("R4", 16'h1000);
    rd("R4", 16'h1004);
    // R5: pending writes discarded
    wrr("R5", 16'h1000, 32'h0000_0000);
    wrr("R5", 16'h1004, 32'hFFFF_FFFF);
    rd("R5", 16'h1000);
    // R6: enable layout and masking
    wrr("R6", 16'h2080, 32'hFFFF_FFFF);
    wrr("R6", 16'h2084, 32'hFFFF_FFFF);
    wrr("R6", 16'h2000, 32'h0000_00A5);
    rd("R6", 16'h2080);
    rd("R6", 16'h2084);
    rd("R6", 16'h2000);
    rd("R6", 16'h2004);
    // R7: out-of-range enable words
    wrr("R7", 16'h2088, 32'hFFFF_FFFF);
    wrr("R7", 16'h20FC, 32'h1234_5678);
    rd("R7", 16'h2088);
    rd("R7", 16'h207C);
    // R8: thresholds
    wrr("R8", 16'h4000, 32'd5);
    wrr("R8", 16'h4000, 32'd7);
    wrr("R8", 16'h4000, 32'd8);
    wrr("R8", 16'h5000, 32'h8000_0001);
    wrr("R8", 16'h5000, 32'd3);
    rd("R8", 16'h4000);
    rd("R8", 16'h5000);
    // R9: claims, including a held request during the busy cycle
    cid0 = 6'd17; cid1 = 6'd40;
    rd("R9", 16'h4004);
    rd("R9", 16'h5004);
    access("R9", 1'b0, 16'h4004, 32'd0, 1'b1);
    cid1 = 6'd0;
    access("R9", 1'b0, 16'h5004, 32'd0, 1'b1);
    // R10: completions
    wrr("R10", 16'h5004, 32'd17);
    wrr("R10", 16'h4004, 32'd40);
    wrr("R10", 16'h4004, 32'd0);
    wrr("R10", 16'h5004, 32'd41);
    wrr("R10", 16'h4004, 32'h0000_0101);
    wrr("R10", 16'h4004, 32'd1);
    // R11: idle cycles stay quiet
    curReq = "R11";
    repeat (4) tick();

    summary();
    $finish;
  end
endmodule